// File: doc/BRIEF.md
# Double-Buffered Segmented Converter Code Register

This block is the digital front end of a 12-bit multiplying converter. A host writes the code word into three 4-bit input segments that share one data bus, so a host bus 4, 8 or 16 bits wide can assemble the full word. An access enables one segment or any mix of them. A separate holding register drives the converter code. A transfer strobe copies the assembled word into that register. Until then, the value the converter sees does not change.

The strobes are level-sensitive. The block samples them on every clock and models them as transparent latches. While a segment's write strobe is active, the segment follows the bus. When the strobe drops, the segment keeps the last value it took. The transfer strobe is independent of the chip enable. A width monitor checks every strobe against a minimum number of cycles and raises a sticky error flag when one is too short. The output code is plain binary for unipolar use and offset binary for bipolar use, where only the MSB set is mid-scale. The block treats both the same way, as a 12-bit word.

Top module: `dac_dbuf_front`

## Requirements
- R1: Each input segment is written only when its own enable is set. Segments whose enable is clear keep their contents, whatever mix of enables is set.
- R2: Enable bit 2 writes `data_in[11:8]` (the MSB nibble), bit 1 writes `data_in[7:4]`, and bit 0 writes `data_in[3:0]` (the LSB nibble), to the same positions of the word.
- R3: A segment accepts data only while `chip_en_n` is low. A segment enable with `chip_en_n` high leaves that segment unchanged.
- R4: While a segment's write strobe is active, the segment takes the bus value on every clock. After the strobe drops, later bus changes have no effect on it.
- R5: On every clock with `xfer` high, the holding register loads the assembled word, whatever the level of `chip_en_n`.
- R6: `code_out` always shows the holding register. Writes to the segments alone leave it unchanged.
- R7: When a segment write and `xfer` occur in the same clock, the holding register takes the value written in that clock.
- R8: `code_upd` is high for exactly the cycles in which `code_out` differs from its value in the previous cycle. A transfer of an unchanged word gives no pulse.
- R9: `width_err` becomes 1 when any of these stays active for fewer than `MIN_PULSE` consecutive clocks: chip enable, transfer, any raw segment enable, or any overlap of chip enable with a segment enable. It then stays 1 until reset.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears all segments, the holding register, `code_upd` and `width_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en_n | input | 1 | Chip enable, active low, gates segment writes |
| seg_en | input | 3 | Segment enables: [2] MSB nibble, [1] middle, [0] LSB nibble |
| xfer | input | 1 | Transfer strobe, active high, copies the word to the holding register |
| data_in | input | 12 | Shared data bus, bit 11 is the MSB |
| code_out | output | 12 | Converter code from the holding register |
| code_upd | output | 1 | High in each cycle whose `code_out` differs from the previous cycle |
| width_err | output | 1 | Sticky flag for a strobe shorter than `MIN_PULSE` cycles |

## Verification
On every cycle, the assertions check four things:
- the output holds still unless a transfer was sampled;
- the update pulse matches each change of the output, in both directions;
- the segments stay frozen while chip enable is inactive;
- a transfer with no concurrent write copies the assembled word and the error flag stays set.

Only the bench scenarios can show:
- which nibble each enable lands in;
- that the last bus value inside a strobe wins;
- the same-cycle write-through value;
- that a single too-short strobe trips the flag while strobes of legal width do not.

// File: rtl/dac_front_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing defaults for the segmented converter front end.
// Assumes the word is an integer number of equal segments.
package dac_front_pkg;
    localparam int unsigned DEF_SEG_W     = 4;
    localparam int unsigned DEF_NUM_SEG   = 3;
    localparam int unsigned DEF_MIN_PULSE = 4;
endpackage

// File: rtl/seg_latch_bank.sv
`timescale 1ns/1ps
// Module: seg_latch_bank
// Holds NUM_SEG input segments, each written from its slice of the bus while
// chip enable (active low) and its own enable are both active. Also drives the
// next-state word combinationally, so a same-cycle transfer sees fresh data.
// Assumes synchronous active-low reset; segment 0 is the least significant.
module seg_latch_bank #(
    parameter int unsigned SEG_W   = 4,
    parameter int unsigned NUM_SEG = 3,
    localparam int unsigned WORD_W = SEG_W * NUM_SEG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_en_n,
    input  logic [NUM_SEG-1:0]   seg_en,
    input  logic [WORD_W-1:0]    data_in,
    output logic [WORD_W-1:0]    word_q,
    output logic [WORD_W-1:0]    word_nxt
);
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic wr;
        // Combined write strobe for this segment.
        assign wr = ~chip_en_n & seg_en[g];

        // Next value: transparent while written, otherwise held.
        always_comb begin
            word_nxt[g*SEG_W +: SEG_W] = wr ? data_in[g*SEG_W +: SEG_W]
                                            : word_q[g*SEG_W +: SEG_W];
        end

        // Segment storage with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q[g*SEG_W +: SEG_W] <= '0;
            else        word_q[g*SEG_W +: SEG_W] <= word_nxt[g*SEG_W +: SEG_W];
        end
    end
endmodule

// File: rtl/code_hold_reg.sv
`timescale 1ns/1ps
// Module: code_hold_reg
// Second-rank holding register. It loads the assembled word on every clock with
// the transfer strobe high and pulses upd_q in the cycle its value changes.
// Assumes word_nxt already includes any write made in the same clock.
module code_hold_reg #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [WORD_W-1:0] word_nxt,
    output logic [WORD_W-1:0] code_q,
    output logic              upd_q
);
    logic changing;

    // A transfer counts as an update only when it alters the code.
    assign changing = xfer && (word_nxt != code_q);

    // Holding register and its change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= changing;
            if (xfer) code_q <= word_nxt;
        end
    end
endmodule

// File: rtl/pulse_width_mon.sv
`timescale 1ns/1ps
// Module: pulse_width_mon
// Counts consecutive active cycles of one strobe, saturating at MIN_PULSE.
// Flags short_hit in the first inactive cycle after a run shorter than MIN_PULSE.
// Assumes MIN_PULSE >= 1.
module pulse_width_mon #(
    parameter int unsigned MIN_PULSE = 4,
    localparam int unsigned CW = $clog2(MIN_PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic short_hit
);
    localparam logic [CW-1:0] LIM = CW'(MIN_PULSE);
    logic [CW-1:0] run_cnt;

    // Run-length counter, cleared while the strobe is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_cnt <= '0;
        else if (!active)      run_cnt <= '0;
        else if (run_cnt < LIM) run_cnt <= run_cnt + 1'b1;
    end

    // Falling edge of a run that ended before reaching the limit.
    assign short_hit = !active && (run_cnt != '0) && (run_cnt < LIM);
endmodule

// File: rtl/dac_dbuf_front.sv
`timescale 1ns/1ps
// Module: dac_dbuf_front (top)
// Segmented input latches feeding a transfer-loaded holding register that drives
// the converter code, plus strobe-width monitoring with a sticky error flag.
// Assumes level strobes are sampled once per clock; reset is synchronous, active low.
module dac_dbuf_front
    import dac_front_pkg::*;
#(
    parameter int unsigned SEG_W     = DEF_SEG_W,
    parameter int unsigned NUM_SEG   = DEF_NUM_SEG,
    parameter int unsigned MIN_PULSE = DEF_MIN_PULSE,
    localparam int unsigned WORD_W   = SEG_W * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chip_en_n,
    input  logic [NUM_SEG-1:0] seg_en,
    input  logic               xfer,
    input  logic [WORD_W-1:0]  data_in,
    output logic [WORD_W-1:0]  code_out,
    output logic               code_upd,
    output logic               width_err
);
    localparam int unsigned NCH = 2 + 2 * NUM_SEG;

    logic [WORD_W-1:0] seg_word;
    logic [WORD_W-1:0] seg_next;
    logic [NCH-1:0]    mon_act;
    logic [NCH-1:0]    short_vec;

    seg_latch_bank #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_bank (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .seg_en(seg_en),
        .data_in(data_in), .word_q(seg_word), .word_nxt(seg_next)
    );

    code_hold_reg #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .word_nxt(seg_next),
        .code_q(code_out), .upd_q(code_upd)
    );

    // Strobes under width watch: chip enable, transfer, raw and gated enables.
    assign mon_act[0] = ~chip_en_n;
    assign mon_act[1] = xfer;
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_act
        assign mon_act[2 + s]           = seg_en[s];
        assign mon_act[2 + NUM_SEG + s] = ~chip_en_n & seg_en[s];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mon
        pulse_width_mon #(.MIN_PULSE(MIN_PULSE)) u_mon (
            .clk(clk), .rst_n(rst_n), .active(mon_act[c]), .short_hit(short_vec[c])
        );
    end

    // Sticky width-violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          width_err <= 1'b0;
        else if (|short_vec) width_err <= 1'b1;
    end
endmodule

// File: rtl/dac_dbuf_front_chk.sv
`timescale 1ns/1ps
// Module: dac_dbuf_front_chk
// Property checker bound into dac_dbuf_front; observes ports and the segment word.
module dac_dbuf_front_chk #(
    parameter int unsigned WORD_W  = 12,
    parameter int unsigned NUM_SEG = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chip_en_n,
    input logic [NUM_SEG-1:0] seg_en,
    input logic               xfer,
    input logic [WORD_W-1:0]  seg_word,
    input logic [WORD_W-1:0]  code_out,
    input logic               code_upd,
    input logic               width_err
);
    AST_CODE_HELD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code_out)); // R6

    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> (code_out != $past(code_out))); // R8

    AST_CHANGE_MEANS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |-> code_upd); // R8

    AST_SEG_FROZEN_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |=> $stable(seg_word)); // R3

    AST_XFER_COPIES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && (chip_en_n || seg_en == '0)) |=> (code_out == $past(seg_word))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |=> width_err); // R9
endmodule

bind dac_dbuf_front dac_dbuf_front_chk #(.WORD_W(WORD_W), .NUM_SEG(NUM_SEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .seg_en(seg_en), .xfer(xfer),
    .seg_word(seg_word), .code_out(code_out), .code_upd(code_upd), .width_err(width_err)
);

// File: tb/dac_dbuf_front_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; inputs change on negedge, outputs sampled on negedge.
module dac_dbuf_front_bench;
    localparam int MINW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en_n = 1'b1;
    logic [2:0]  seg_en = '0;
    logic        xfer = 1'b0;
    logic [11:0] data_in = '0;
    logic [11:0] code_out;
    logic        code_upd;
    logic        width_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dac_dbuf_front #(.MIN_PULSE(MINW)) u_dac_dbuf_front (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .seg_en(seg_en), .xfer(xfer),
        .data_in(data_in), .code_out(code_out), .code_upd(code_upd), .width_err(width_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        chip_en_n = 1'b1; seg_en = '0; xfer = 1'b0;
    endtask

    // Write with chip enable for MINW clocks, then release.
    task automatic wr(input logic [2:0] en, input logic [11:0] d);
        @(negedge clk); chip_en_n = 1'b0; seg_en = en; data_in = d;
        repeat (MINW) @(negedge clk);
        idle();
    endtask

    // Transfer for MINW clocks with chip enable off; returns number of update pulses.
    task automatic do_xfer(output int pulses);
        pulses = 0;
        @(negedge clk); xfer = 1'b1;
        repeat (MINW) begin
            @(negedge clk);
            pulses += int'(code_upd);
        end
        idle();
        @(negedge clk);
        pulses += int'(code_upd);
    endtask

    task automatic t_reset();
        chk("R10", "code after reset", code_out, 12'h000);
        chk("R10", "upd after reset", code_upd, 1'b0);
        chk("R10", "err after reset", width_err, 1'b0);
    endtask

    task automatic t_segments();
        int p;
        wr(3'b100, 12'hABC);
        chk("R6", "code unchanged by segment write", code_out, 12'h000);
        wr(3'b001, 12'h123);
        do_xfer(p);
        chk("R2", "high and low nibble placement", code_out, 12'hA03);
        chk("R8", "one pulse on change", p, 1);
        wr(3'b010, 12'h050);
        do_xfer(p);
        chk("R1", "middle only, others kept", code_out, 12'hA53);
    endtask

    task automatic t_cs_gate();
        int p;
        @(negedge clk); chip_en_n = 1'b1; seg_en = 3'b111; data_in = 12'hFFF;
        repeat (MINW) @(negedge clk);
        idle();
        do_xfer(p);
        chk("R3", "enables without chip enable ignored", code_out, 12'hA53);
        chk("R8", "no pulse on unchanged transfer", p, 0);
    endtask

    task automatic t_level();
        int p;
        @(negedge clk); chip_en_n = 1'b0; seg_en = 3'b010; data_in = 12'h070;
        repeat (2) @(negedge clk);
        data_in = 12'h090;
        repeat (MINW) @(negedge clk);
        idle();
        data_in = 12'hFFF;
        repeat (3) @(negedge clk);
        do_xfer(p);
        chk("R4", "last value in strobe kept, later bus ignored", code_out, 12'hA93);
        chk("R5", "transfer with chip enable inactive", p, 1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); chip_en_n = 1'b0; seg_en = 3'b100; data_in = 12'h6EE; xfer = 1'b1;
        @(negedge clk);
        chk("R7", "write-through on same clock", code_out, 12'h693);
        chk("R8", "pulse in change cycle", code_upd, 1'b1);
        @(negedge clk);
        chk("R8", "pulse lasts one cycle", code_upd, 1'b0);
        repeat (MINW - 2) @(negedge clk);
        idle();
        @(negedge clk);
        chk("R9", "legal widths leave flag clear", width_err, 1'b0);
    endtask

    task automatic t_width();
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "short transfer strobe flagged", width_err, 1'b1);
        repeat (MINW + 2) @(negedge clk);
        chk("R9", "flag sticky", width_err, 1'b1);
    endtask

    task automatic t_rst_clear();
        int p;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "code cleared", code_out, 12'h000);
        chk("R10", "flag cleared", width_err, 1'b0);
        wr(3'b001, 12'h004);
        do_xfer(p);
        chk("R10", "other segments cleared", code_out, 12'h004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_segments();
        t_cs_gate();
        t_level();
        t_same_cycle();
        t_width();
        t_rst_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule